// File: doc/BRIEF.md
# Write Burst Engine with Read Truncation

This block sits on the controller side of a double-data-rate memory interface. It issues one write command, then drives the write burst of 2, 4 or 8 words, one word slot per clock. For each slot it produces the bus-drive enable, the data-mask bit and the index of the word the data path must present. The DDR strobe phase and the read capture path are handled outside the block. A read request that arrives while a burst is in flight can cut that burst short. The block masks the word just before the read command and the word that coincides with it, commits every earlier word, and drives nothing after that. Each write ends with a one-cycle done pulse that carries the number of words actually stored.

Cutting a burst short is only legal at the slower clock grades, so an input turns the feature off. With it off, a pending read waits until the burst has finished and one idle clock has passed. Requests are level-held: the upstream logic keeps the read request high until it sees the read command on the command output. A write request is accepted only while `wr_ready` is high.

Top module: `wrcut_engine`

## Requirements
- R1: During and just after synchronous reset, `cmd_o` is NOP (2'b00), `dq_oe`, `dm` and `done` are low and `wr_ready` is high.
- R2: `cfg_len_code` selects the burst length: 0 gives 2 words, 1 gives 4, and 2 or 3 gives 8. An accepted write puts WRITE (2'b01) on `cmd_o` in the next cycle W. Word k is driven in cycle W+1+k with `word_idx` equal to k.
- R3: An uncut burst ends with a `done` pulse in cycle W+BL+1, where `done_count` equals BL and `dq_oe` is low. `wr_ready` is low while the burst drives the bus.
- R4: With cutting enabled, a read request first sampled on the edge that starts word k (k < BL) causes word k to be driven with `dm` high. READ (2'b10) follows in the next cycle, and word k+1 is also driven masked in that cycle if k+1 < BL.
- R5: A READ command never follows a WRITE command by less than two cycles. A read pending during the write command is issued at W+2, with no word committed.
- R6: In a cut burst, the `done` pulse comes in the READ cycle and `done_count` equals k, the number of unmasked words already driven.
- R7: `dq_oe` is low in every cycle after a READ command until the next write's data. This leaves at least one clock of bus turnaround before read data at a latency of 2.5 or 3.
- R8: With cutting disabled, a read request raised during a burst is issued at W+BL+2, one idle clock after the last word. The burst completes unmasked.
- R9: A read request while idle yields READ in the next cycle. When both requests are present while idle, the write is taken first.
- R10: `dm` is high only while `dq_oe` is high, and consecutive driven words carry consecutive indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len_code | input | 2 | Burst length select, latched when a write is accepted |
| cfg_cut_en | input | 1 | Allows a read to truncate a write burst, latched when a write is accepted |
| wr_req | input | 1 | Write burst request, taken when `wr_ready` is high |
| rd_req | input | 1 | Read request, held high until READ appears on `cmd_o` |
| wr_ready | output | 1 | Engine can accept a write this cycle |
| cmd_o | output | 2 | Command: 00 NOP, 01 WRITE, 10 READ |
| dq_oe | output | 1 | Controller drives data bus and strobe |
| dm | output | 1 | Mask for the word in the current slot |
| word_idx | output | IDX_W (3) | Index of the word to present in the current slot |
| done | output | 1 | One-cycle pulse ending a write |
| done_count | output | CNT_W (4) | Words committed by the write that just ended |

## Verification
The hardest situation to reach is a read landing on the last word slot of a burst. There the pre-read word is masked but no post-read word exists, so only one masked word is driven. The stimulus raises the read request in the exact cycle counted from the observed WRITE command. A vector table walks read arrival offsets from the write command itself through the last word and past the burst end, for each length and with cutting on and off. The boundary case with cutting enabled and the request arriving exactly at burst end checks that the request falls through to the ordinary post-burst read.

// File: rtl/wc_pkg.sv
// Shared types for the write-burst truncation engine.
// Assumes: one word slot per clock; DDR phase handled downstream.
package wc_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_READ  = 2'b10
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,   // nothing in flight
        ST_WCMD,   // write command slot
        ST_BEAT,   // unmasked word slot
        ST_PRE,    // masked word ahead of the read
        ST_RCUT,   // read command cutting the burst
        ST_TAIL,   // cycle after a full burst, done pulse
        ST_RCMD    // plain read command
    } st_e;

endpackage

// File: rtl/wc_len_dec.sv
// Burst length decoder: maps the 2-bit select to a word count.
// Assumes: codes above the largest supported length clamp to MAX_BL.
module wc_len_dec #(
    parameter int MAX_BL = 8,
    parameter int CNT_W  = 4
) (
    input  logic [1:0]       code,
    output logic [CNT_W-1:0] len
);

    // Doubling per code step, clamped at the maximum length.
    always_comb begin
        int unsigned raw;
        raw = 32'd2 << code;
        if (raw > MAX_BL)
            len = CNT_W'(MAX_BL);
        else
            len = CNT_W'(raw);
    end

endmodule

// File: rtl/wc_beat_ctr.sv
// Word slot counter for a burst; flags the final slot.
// Assumes: clear and step are never asserted together by the sequencer.
module wc_beat_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] len,
    output logic [CNT_W-1:0] idx,
    output logic             last
);

    // Slot index register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (clear)
            idx <= '0;
        else if (step)
            idx <= idx + 1'b1;
    end

    // Final slot of the burst.
    assign last = (idx == len - 1'b1);

endmodule

// File: rtl/wc_seq_fsm.sv
// Sequencer deciding write, word slots, cut and read issue.
// Assumes: rd_req is held until READ is observed; cut_en is latched per burst.
module wc_seq_fsm
    import wc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    input  logic rd_req,
    input  logic cut_en,
    input  logic last,
    output st_e  state
);

    st_e nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_TAIL: begin
                if (wr_req)      nxt = ST_WCMD;
                else if (rd_req) nxt = ST_RCMD;
                else             nxt = ST_IDLE;
            end
            ST_WCMD:
                nxt = (cut_en && rd_req) ? ST_PRE : ST_BEAT;
            ST_BEAT: begin
                if (last)                  nxt = ST_TAIL;
                else if (cut_en && rd_req) nxt = ST_PRE;
                else                       nxt = ST_BEAT;
            end
            ST_PRE:  nxt = ST_RCUT;
            ST_RCUT: nxt = ST_IDLE;
            ST_RCMD: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

endmodule

// File: rtl/wrcut_engine.sv
// Write burst engine with optional read truncation.
// Issues WRITE, drives word slots, masks the two words around a
// cutting read, and reports the committed word count.
// Assumes: one word slot per clock, write data latency of one clock.
module wrcut_engine
    import wc_pkg::*;
#(
    parameter  int MAX_BL = 8,
    localparam int IDX_W  = $clog2(MAX_BL),
    localparam int CNT_W  = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_len_code,
    input  logic             cfg_cut_en,
    input  logic             wr_req,
    input  logic             rd_req,
    output logic             wr_ready,
    output logic [1:0]       cmd_o,
    output logic             dq_oe,
    output logic             dm,
    output logic [IDX_W-1:0] word_idx,
    output logic             done,
    output logic [CNT_W-1:0] done_count
);

    st_e              state;
    logic [CNT_W-1:0] len_dec;
    logic [CNT_W-1:0] len_q;
    logic             cut_q;
    logic [CNT_W-1:0] idx;
    logic             last;
    logic             accept;
    logic             step;
    logic             post_ok;
    cmd_e             cmd;

    wc_len_dec #(.MAX_BL(MAX_BL), .CNT_W(CNT_W)) u_len (
        .code (cfg_len_code),
        .len  (len_dec)
    );

    assign wr_ready = (state == ST_IDLE) || (state == ST_TAIL);
    assign accept   = wr_ready && wr_req;

    // Per-burst configuration capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= CNT_W'(2);
            cut_q <= 1'b0;
        end else if (accept) begin
            len_q <= len_dec;
            cut_q <= cfg_cut_en;
        end
    end

    assign step = ((state == ST_BEAT) && !last) || (state == ST_PRE);

    wc_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  (step),
        .len   (len_q),
        .idx   (idx),
        .last  (last)
    );

    wc_seq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (wr_req),
        .rd_req (rd_req),
        .cut_en (cut_q),
        .last   (last),
        .state  (state)
    );

    // Word after the read exists only if the burst had one left.
    assign post_ok = (idx < len_q);

    // Command output decode.
    always_comb begin
        unique case (state)
            ST_WCMD:          cmd = CMD_WRITE;
            ST_RCUT, ST_RCMD: cmd = CMD_READ;
            default:          cmd = CMD_NOP;
        endcase
    end
    assign cmd_o = cmd;

    // Bus drive, mask and slot index.
    always_comb begin
        dq_oe = 1'b0;
        dm    = 1'b0;
        unique case (state)
            ST_BEAT: dq_oe = 1'b1;
            ST_PRE: begin
                dq_oe = 1'b1;
                dm    = 1'b1;
            end
            ST_RCUT: begin
                dq_oe = post_ok;
                dm    = post_ok;
            end
            default: ;
        endcase
        word_idx = dq_oe ? idx[IDX_W-1:0] : '0;
    end

    // Completion report.
    always_comb begin
        done       = 1'b0;
        done_count = '0;
        if (state == ST_RCUT) begin
            done       = 1'b1;
            done_count = idx - 1'b1;
        end else if (state == ST_TAIL) begin
            done       = 1'b1;
            done_count = len_q;
        end
    end

endmodule

// File: rtl/wrcut_engine_chk.sv
// Protocol checker for wrcut_engine, attached by bind.
// Assumes: observes only top-level ports.
module wrcut_engine_chk #(
    parameter  int MAX_BL = 8,
    localparam int IDX_W  = $clog2(MAX_BL),
    localparam int CNT_W  = IDX_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_ready,
    input logic [1:0]       cmd_o,
    input logic             dq_oe,
    input logic             dm,
    input logic [IDX_W-1:0] word_idx,
    input logic             done,
    input logic [CNT_W-1:0] done_count
);

    assert_read_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'b10) |-> ($past(cmd_o) != 2'b01));

    assert_first_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'b01) |=> (dq_oe && word_idx == '0));

    assert_ready_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !dq_oe);

    assert_done_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_count <= CNT_W'(MAX_BL)));

    assert_bus_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'b10) |=> !dq_oe);

    assert_mask_driven_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dm |-> dq_oe);

    assert_idx_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(dq_oe)) |-> (word_idx == IDX_W'($past(word_idx) + 1'b1)));

endmodule

bind wrcut_engine wrcut_engine_chk #(.MAX_BL(MAX_BL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ready   (wr_ready),
    .cmd_o      (cmd_o),
    .dq_oe      (dq_oe),
    .dm         (dm),
    .word_idx   (word_idx),
    .done       (done),
    .done_count (done_count)
);

// File: tb/wrcut_engine_tb.sv
// Self-checking bench for wrcut_engine: vector table then directed cases.
module wrcut_engine_tb;

    localparam int MAX_BL = 8;
    localparam int IDX_W  = $clog2(MAX_BL);
    localparam int CNT_W  = IDX_W + 1;
    localparam int WIN    = 14;
    localparam int NV     = 8;

    typedef struct packed {
        logic [1:0] code;
        logic       cut;
        logic [7:0] rd_at;    // cycle after W in which rd_req rises, 255 none
        logic [7:0] rd_off;   // expected READ offset from W, 255 none
        logic [7:0] done_off; // expected done offset from W
        logic [7:0] commit;   // expected done_count and unmasked words
        logic [7:0] masked;   // expected masked driven words
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b1, 8'd0,   8'd2,   8'd2, 8'd0, 8'd2},  // R5 cut at first word
        '{2'd2, 1'b1, 8'd3,   8'd5,   8'd5, 8'd3, 8'd2},  // R4 mid-burst cut
        '{2'd2, 1'b1, 8'd7,   8'd9,   8'd9, 8'd7, 8'd1},  // R4 cut on last word
        '{2'd0, 1'b1, 8'd1,   8'd3,   8'd3, 8'd1, 8'd1},  // R4 short burst cut
        '{2'd2, 1'b0, 8'd2,   8'd10,  8'd9, 8'd8, 8'd0},  // R8 cut disabled
        '{2'd1, 1'b1, 8'd4,   8'd6,   8'd5, 8'd4, 8'd0},  // R8 request at burst end
        '{2'd3, 1'b0, 8'd255, 8'd255, 8'd9, 8'd8, 8'd0},  // R2 code 3 gives 8
        '{2'd0, 1'b0, 8'd0,   8'd4,   8'd3, 8'd2, 8'd0}   // R8 short burst waits
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       cfg_len_code = 2'd0;
    logic             cfg_cut_en = 1'b0;
    logic             wr_req = 1'b0;
    logic             rd_req = 1'b0;
    logic             wr_ready;
    logic [1:0]       cmd_o;
    logic             dq_oe;
    logic             dm;
    logic [IDX_W-1:0] word_idx;
    logic             done;
    logic [CNT_W-1:0] done_count;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wrcut_engine #(.MAX_BL(MAX_BL)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_len_code (cfg_len_code),
        .cfg_cut_en   (cfg_cut_en),
        .wr_req       (wr_req),
        .rd_req       (rd_req),
        .wr_ready     (wr_ready),
        .cmd_o        (cmd_o),
        .dq_oe        (dq_oe),
        .dm           (dm),
        .word_idx     (word_idx),
        .done         (done),
        .done_count   (done_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        summary();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(cmd_o == 2'b00, "R1 cmd in reset", cmd_o, 0);
        chk(!dq_oe && !dm && !done, "R1 drive/mask/done in reset", {dq_oe, dm, done}, 0);
        chk(wr_ready, "R1 ready in reset", wr_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_o == 2'b00 && !dq_oe, "R1 idle after reset", cmd_o, 0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            int rd_seen, done_seen, cnt_seen, unm, msk, bad_order, oe_after;
            bit raised;
            rd_seen = 255; done_seen = 255; cnt_seen = -1;
            unm = 0; msk = 0; bad_order = 0; oe_after = 0; raised = 0;
            cfg_len_code = VECS[v].code;
            cfg_cut_en   = VECS[v].cut;
            wr_req = 1'b1;
            @(negedge clk);
            wr_req = 1'b0;
            chk(cmd_o == 2'b01, "R2 WRITE one cycle after accept", cmd_o, 1);
            for (int t = 0; t < WIN; t++) begin
                if (cmd_o == 2'b10 && rd_seen == 255) rd_seen = t;
                if (dq_oe) begin
                    if (dm) msk++; else unm++;
                    if (int'(word_idx) != t - 1) bad_order++;
                    if (rd_seen != 255 && t > rd_seen) oe_after++;
                end
                if (done && done_seen == 255) begin
                    done_seen = t;
                    cnt_seen  = done_count;
                end
                if (cmd_o == 2'b10) rd_req = 1'b0;
                if (!raised && t == int'(VECS[v].rd_at)) begin
                    rd_req = 1'b1;
                    raised = 1;
                end
                @(negedge clk);
            end
            rd_req = 1'b0;
            chk(rd_seen == int'(VECS[v].rd_off), "R4/R5/R8 read offset", rd_seen, VECS[v].rd_off);
            chk(done_seen == int'(VECS[v].done_off), "R3/R6 done offset", done_seen, VECS[v].done_off);
            chk(cnt_seen == int'(VECS[v].commit), "R3/R6 done_count", cnt_seen, VECS[v].commit);
            chk(unm == int'(VECS[v].commit), "R6 unmasked words", unm, VECS[v].commit);
            chk(msk == int'(VECS[v].masked), "R4 masked words", msk, VECS[v].masked);
            chk(bad_order == 0, "R10 word order", bad_order, 0);
            chk(oe_after == 0, "R7 bus released after READ", oe_after, 0);
            repeat (2) @(negedge clk);
        end

        // R9 idle read
        rd_req = 1'b1;
        @(negedge clk);
        chk(cmd_o == 2'b10, "R9 idle read issued", cmd_o, 2);
        rd_req = 1'b0;
        @(negedge clk);
        chk(cmd_o == 2'b00, "R9 single read", cmd_o, 0);

        // R9 write priority, then R5 earliest cut, R3 ready low while driving
        cfg_len_code = 2'd1;
        cfg_cut_en   = 1'b1;
        wr_req = 1'b1;
        rd_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        chk(cmd_o == 2'b01, "R9 write before read", cmd_o, 1);
        @(negedge clk);
        chk(cmd_o == 2'b00 && dq_oe && dm, "R5 no read at W+1, word masked", {cmd_o, dq_oe, dm}, 3);
        chk(!wr_ready, "R3 ready low while driving", wr_ready, 0);
        @(negedge clk);
        chk(cmd_o == 2'b10 && done && done_count == 0, "R5/R6 read at W+2 commits none", done_count, 0);
        rd_req = 1'b0;
        @(negedge clk);
        chk(!dq_oe && cmd_o == 2'b00, "R7 released after cut", dq_oe, 0);

        summary();
    end

endmodule